// File: doc/BRIEF.md
# Byte-Split Double-Buffered DAC Loader

This block is the digital front end of a 12-bit digital-to-analog converter whose host side is only 8 bits wide. A 12-bit word is built in an input register from two writes over a right-justified byte bus:

- One select, together with a shared write strobe, fills the low eight bits.
- A second select, with the same write strobe, fills the top four bits from the low nibble of the bus.

A separate load strobe copies the assembled word into the output register. The output register drives the converter code. Because the load strobe is separate from the writes, many instances sharing one load line can change their outputs together.

All strobes are active low and come from another timing domain. Each passes through a synchronizer of `SYNC_STAGES` flops before it acts. The bus is not synchronized. It must be held stable while a write is being acted on.

A mode input can bind the load action to one of the two selects. The host can then write the first part and let the second write update the output at the same time. A flag reports that both halves have been written since the last transfer.

Top module: `dac_split_loader`

## Requirements
- R1: After reset, `dac_code` is 0, the input word is 0 and `pair_ready` is 0.
- R2: With `lo_sel_n` and `wr_n` both low, `bus_data[7:0]` is loaded into input bits 7..0. Those bits keep their value in every cycle where that pair is not both low.
- R3: With `hi_sel_n` and `wr_n` both low, `bus_data[3:0]` is loaded into input bits 11..8, and `bus_data[7:4]` has no effect. Those bits keep their value otherwise.
- R4: Writing the low part then the high part gives the same word as writing the high part then the low part.
- R5: With `xfer_mode` = 2'b00, while the load strobe `ld_n` is low `dac_code` follows the input word. While `ld_n` is high, `dac_code` holds.
- R6: With `hi_sel_n`, `wr_n` and `ld_n` low together, the nibble is written and the whole new word reaches `dac_code` in the same operation.
- R7: While every strobe is high, neither register changes, whatever the bus does.
- R8: `xfer_mode` selects where the load action comes from:
  - 2'b01: the load action follows `hi_sel_n`, and `ld_n` is ignored.
  - 2'b10: the load action follows `lo_sel_n`, and `ld_n` is ignored.
  - 2'b00 and 2'b11: the load action follows `ld_n`.
- R9: If both selects are low during one write, both parts are loaded from the bus in that operation.
- R10: `pair_ready` is set once both parts have been written since the last transfer. It is 0 after any cycle in which a transfer acts, and a write in that same cycle does not set it.
- R11: A strobe level sampled at rising edge k acts on the registers at edge k+`SYNC_STAGES`. With the default of 2, a load that is first seen at an edge shows on `dac_code` after the second edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Right-justified data bus |
| lo_sel_n | input | 1 | Active-low select of input bits 7..0 |
| hi_sel_n | input | 1 | Active-low select of input bits 11..8 |
| wr_n | input | 1 | Active-low write strobe shared by both selects |
| ld_n | input | 1 | Active-low load strobe, input word to output register |
| xfer_mode | input | 2 | Transfer source: 00/11 external load, 01 high select, 10 low select |
| dac_code | output | 12 | Output register, the converter code |
| pair_ready | output | 1 | Both halves written since the last transfer |

## Verification
The hardest case to reach is a write and a transfer acting in the same synchronized cycle. In that case the new nibble must reach `dac_code` and `pair_ready` must stay clear. The bench reaches it by dropping the high select, the write strobe and the load strobe at one falling edge, so that all three pass through the synchronizer together. It reaches it a second time through automatic-transfer mode, where the high select alone produces both the write and the transfer. The automatic modes are also run with `ld_n` held low throughout, which shows that the external load line has no effect there.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
    // Source of the transfer action
    typedef enum logic [1:0] {
        XFER_EXT = 2'b00,
        XFER_HI  = 2'b01,
        XFER_LO  = 2'b10,
        XFER_RSV = 2'b11
    } xfer_mode_e;

    // Bit positions of the strobes inside the synchronized vector
    localparam int STB_WR = 0;
    localparam int STB_LO = 1;
    localparam int STB_HI = 2;
    localparam int STB_LD = 3;
    localparam int STB_N  = 4;
endpackage

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_n,
    output logic [WIDTH-1:0] sync_n
);
    typedef logic [WIDTH-1:0] vec_t;

    vec_t stage_d [STAGES];
    vec_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = raw_n;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // Strobes reset to the inactive (high) level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/dac_input_reg.sv
module dac_input_reg #(
    parameter int DATA_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic              xfer,
    output logic [DATA_W-1:0] word_q,
    output logic [DATA_W-1:0] word_next,
    output logic              ready
);
    localparam int HI_W = DATA_W - BUS_W;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              lo_seen;
        logic              hi_seen;
    } in_state_t;

    in_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_wr) st_d.word[BUS_W-1:0] = bus;
        if (hi_wr) st_d.word[DATA_W-1:BUS_W] = bus[HI_W-1:0];
        if (xfer) begin
            st_d.lo_seen = 1'b0;
            st_d.hi_seen = 1'b0;
        end else begin
            st_d.lo_seen = st_q.lo_seen | lo_wr;
            st_d.hi_seen = st_q.hi_seen | hi_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_q    = st_q.word;
    assign word_next = st_d.word;
    assign ready     = st_q.lo_seen & st_q.hi_seen;

    // R2
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> word_q[BUS_W-1:0] == $past(bus));
    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> $stable(word_q[BUS_W-1:0]));
    // R3
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> word_q[DATA_W-1:BUS_W] == $past(bus[HI_W-1:0]));
    // R3
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> $stable(word_q[DATA_W-1:BUS_W]));
    // R10
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !ready);
endmodule

// File: rtl/dac_output_reg.sv
module dac_output_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [DATA_W-1:0] word_next,
    output logic [DATA_W-1:0] code_q
);
    typedef struct packed {
        logic [DATA_W-1:0] code;
    } out_state_t;

    out_state_t st_d, st_q;

    // Transparent while transfer is active: passes this cycle's new word
    always_comb begin
        st_d = st_q;
        if (xfer) st_d.code = word_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_q = st_q.code;

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(code_q));
endmodule

// File: rtl/dac_split_loader.sv
module dac_split_loader
    import dac_loader_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              lo_sel_n,
    input  logic              hi_sel_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [1:0]        xfer_mode,
    output logic [DATA_W-1:0] dac_code,
    output logic              pair_ready
);
    logic [STB_N-1:0]  raw_n, sync_n;
    logic              lo_wr, hi_wr, xfer;
    logic [DATA_W-1:0] in_word_q, in_word_next;
    xfer_mode_e        mode;

    always_comb begin
        raw_n         = '1;
        raw_n[STB_WR] = wr_n;
        raw_n[STB_LO] = lo_sel_n;
        raw_n[STB_HI] = hi_sel_n;
        raw_n[STB_LD] = ld_n;
    end

    dac_strobe_sync #(.WIDTH(STB_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (raw_n),
        .sync_n (sync_n)
    );

    assign mode  = xfer_mode_e'(xfer_mode);
    assign lo_wr = ~sync_n[STB_LO] & ~sync_n[STB_WR];
    assign hi_wr = ~sync_n[STB_HI] & ~sync_n[STB_WR];

    always_comb begin
        unique case (mode)
            XFER_HI: xfer = ~sync_n[STB_HI];
            XFER_LO: xfer = ~sync_n[STB_LO];
            default: xfer = ~sync_n[STB_LD];
        endcase
    end

    dac_input_reg #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus       (bus_data),
        .lo_wr     (lo_wr),
        .hi_wr     (hi_wr),
        .xfer      (xfer),
        .word_q    (in_word_q),
        .word_next (in_word_next),
        .ready     (pair_ready)
    );

    dac_output_reg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .word_next (in_word_next),
        .code_q    (dac_code)
    );

    // R5
    code_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> dac_code == in_word_q);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (dac_code == '0) && (in_word_q == '0) && !pair_ready);
    // R10
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && lo_wr && hi_wr) |=> pair_ready);
endmodule

// File: tb/dac_split_loader_test.sv
`timescale 1ns/1ps
module dac_split_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = 8'h00;
    logic        lo_sel_n = 1'b1, hi_sel_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
    logic [1:0]  xfer_mode = 2'b00;
    logic [11:0] dac_code;
    logic        pair_ready;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    dac_split_loader uut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
        .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n), .wr_n(wr_n), .ld_n(ld_n),
        .xfer_mode(xfer_mode), .dac_code(dac_code), .pair_ready(pair_ready)
    );

    // Behavioural reference: strobes delayed two edges, then applied
    bit [3:0] m1, m2;    // {ld, hi, lo, wr}, active low
    int  m_word, m_dac;
    bit  m_lo_f, m_hi_f;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 = 4'hF; m2 = 4'hF;
            m_word = 0; m_dac = 0; m_lo_f = 0; m_hi_f = 0;
        end else begin
            bit lw, hw, ld;
            lw = !m2[1] && !m2[0];
            hw = !m2[2] && !m2[0];
            case (xfer_mode)
                2'b01:   ld = !m2[2];
                2'b10:   ld = !m2[1];
                default: ld = !m2[3];
            endcase
            if (lw) m_word = (m_word & 'hF00) | int'(bus_data);
            if (hw) m_word = (m_word & 'h0FF) | ((int'(bus_data) & 'hF) << 8);
            if (ld) begin
                m_dac = m_word; m_lo_f = 0; m_hi_f = 0;
            end else begin
                if (lw) m_lo_f = 1;
                if (hw) m_hi_f = 1;
            end
            m2 = m1;
            m1 = {ld_n, hi_sel_n, lo_sel_n, wr_n};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (int'(dac_code) != m_dac || pair_ready != (m_lo_f && m_hi_f)) begin
                n_bad++;
                $display("FAIL %s model: dac_code=%h ready=%0b expected %h ready=%0b",
                         cur_req, dac_code, pair_ready, m_dac[11:0], m_lo_f && m_hi_f);
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_part(input bit lo, input bit hi, input bit ld, input logic [7:0] v);
        @(negedge clk);
        bus_data = v;
        if (lo) lo_sel_n = 1'b0;
        if (hi) hi_sel_n = 1'b0;
        if (ld) ld_n = 1'b0;
        wr_n = 1'b0;
        idle(2);
        wr_n = 1'b1; lo_sel_n = 1'b1; hi_sel_n = 1'b1;
        if (ld) ld_n = 1'b1;
        idle(4);
    endtask

    task automatic pulse_ld();
        @(negedge clk);
        ld_n = 1'b0;
        idle(2);
        ld_n = 1'b1;
        idle(4);
    endtask

    bit done = 0;

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        cur_req = "R1";
        check("R1 dac_code", int'(dac_code), 0);
        check("R1 pair_ready", int'(pair_ready), 0);

        cur_req = "R2";
        write_part(1, 0, 0, 8'hA5);
        check("R2 held before load", int'(dac_code), 0);
        cur_req = "R10";
        check("R10 one part only", int'(pair_ready), 0);
        write_part(0, 1, 0, 8'h3C);
        check("R10 both parts", int'(pair_ready), 1);
        cur_req = "R5";
        check("R5 hold while ld_n high", int'(dac_code), 0);
        pulse_ld();
        check("R5 transfer", int'(dac_code), 'hCA5);
        check("R10 cleared on transfer", int'(pair_ready), 0);

        cur_req = "R3";
        write_part(0, 1, 0, 8'hF7);
        pulse_ld();
        check("R3 upper bus bits ignored", int'(dac_code), 'h7A5);

        cur_req = "R4";
        write_part(0, 1, 0, 8'h02);
        write_part(1, 0, 0, 8'h11);
        pulse_ld();
        check("R4 high then low", int'(dac_code), 'h211);
        write_part(1, 0, 0, 8'h11);
        write_part(0, 1, 0, 8'h02);
        pulse_ld();
        check("R4 low then high", int'(dac_code), 'h211);

        cur_req = "R7";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            bus_data = 8'(i * 37 + 5);
        end
        idle(3);
        check("R7 idle keeps output", int'(dac_code), 'h211);
        pulse_ld();
        check("R7 idle keeps input word", int'(dac_code), 'h211);

        cur_req = "R9";
        write_part(1, 1, 0, 8'h9E);
        check("R9 both parts flag", int'(pair_ready), 1);
        pulse_ld();
        check("R9 both selects", int'(dac_code), 'hE9E);

        cur_req = "R6";
        write_part(1, 0, 0, 8'h34);
        write_part(0, 1, 1, 8'h05);
        check("R6 write and load together", int'(dac_code), 'h534);
        check("R6 flag stays clear", int'(pair_ready), 0);

        cur_req = "R8";
        ld_n = 1'b0;
        xfer_mode = 2'b01;
        write_part(1, 0, 0, 8'h66);
        check("R8 mode01 ld_n ignored", int'(dac_code), 'h534);
        write_part(0, 1, 0, 8'h08);
        check("R8 mode01 high write updates", int'(dac_code), 'h866);
        xfer_mode = 2'b10;
        write_part(0, 1, 0, 8'h01);
        check("R8 mode10 ld_n ignored", int'(dac_code), 'h866);
        write_part(1, 0, 0, 8'h77);
        check("R8 mode10 low write updates", int'(dac_code), 'h177);
        ld_n = 1'b1;
        idle(4);
        xfer_mode = 2'b11;
        write_part(0, 1, 0, 8'h04);
        write_part(1, 0, 0, 8'hC3);
        check("R8 mode11 no auto transfer", int'(dac_code), 'h177);
        pulse_ld();
        check("R8 mode11 external load", int'(dac_code), 'h4C3);
        xfer_mode = 2'b00;
        idle(2);

        cur_req = "R11";
        write_part(1, 0, 0, 8'h5A);
        @(negedge clk);
        ld_n = 1'b0;
        @(negedge clk);
        check("R11 one edge", int'(dac_code), 'h4C3);
        @(negedge clk);
        check("R11 two edges", int'(dac_code), 'h4C3);
        @(negedge clk);
        check("R11 three edges", int'(dac_code), 'h45A);
        ld_n = 1'b1;
        idle(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule